// File: doc/BRIEF.md
# Sequential Ones Counter

This block counts how many bits are set in a data word. It does not use a combinational adder tree. A small control machine drives a shift register and a result counter, and each clock in the counting phase looks at one operand bit. The counting phase ends as soon as the remaining operand is zero, so the count takes as many clocks as the position of the highest set bit.

Use it through a level handshake. While `start` is low, the block keeps reloading the operand from `din`. Raising `start` begins a count. When `busy_done` rises, `ones` holds the result, and it stays valid until `start` is lowered again. `start` may come from a different clock domain: a two-stage (parameterisable) synchronizer retimes it before the controller sees it. Reset is synchronous.

Top module: `ones_counter`

## Requirements
- R1: While reset is applied at a clock edge, the next cycle shows `busy_done`=0 and `ones`=0.
- R2: While the synchronized start is low, the block is idle. `ones` reads 0 and the operand register reloads `din` on every clock.
- R3: After a count finishes, `ones` equals the number of 1 bits in the `din` value that was present SYNC_STAGES clock edges after `start` rose.
- R4: `busy_done` rises exactly SYNC_STAGES+2+k clock edges after `start` rises. Here k is the index of the highest set bit of the operand plus one, and k is 0 for an all-zero word.
- R5: An all-zero operand still reaches the done state, with `ones`=0, after SYNC_STAGES+2 edges.
- R6: While `busy_done` is 1 and `start` stays high, `busy_done` stays 1 and `ones` does not change, whatever `din` does.
- R7: After `start` falls, `busy_done` falls exactly SYNC_STAGES+1 edges later. `ones` reads 0 one clock after that.
- R8: Changes on `din` after the operand has been captured do not change the result of the count in progress.
- R9: `ones` never exceeds DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Asynchronous request level; synchronized inside |
| din | input | DATA_W | Word whose set bits are counted |
| ones | output | $clog2(DATA_W+1) | Number of set bits; valid while busy_done is 1 |
| busy_done | output | 1 | High when the count is complete, until start is dropped |

## Verification
The bench uses the default parameters: an 8-bit word and a two-stage synchronizer. At that width the directed words (zero, the lowest bit alone, the highest bit alone, all ones, alternating patterns) and a few hundred seeded random words together cover every counting length from zero to eight shifts. This makes the exact-latency rule R4 checkable for each span. The two-stage synchronizer fixes the capture edge and the release latency to small known numbers. The bench therefore drives `din` changes on either side of the capture point, which exercises R3 and R8.

// File: rtl/ones_pkg.sv
package ones_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } ones_state_e;

  // Width needed to hold a count from 0 up to w inclusive.
  function automatic int tally_width(input int w);
    return $clog2(w + 1);
  endfunction

endpackage

// File: rtl/ones_sync.sv
module ones_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

  initial begin
    a_r4_stages_min: assert (STAGES >= 2);
  end

endmodule

// File: rtl/ones_ctrl.sv
module ones_ctrl
  import ones_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic opnd_zero,
  output logic ev_load,
  output logic ev_clear,
  output logic ev_shift,
  output logic fin
);

  ones_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (go)        state_nx = ST_COUNT;
      ST_COUNT: if (opnd_zero) state_nx = ST_DONE;
      ST_DONE:  if (!go)       state_nx = ST_IDLE;
      default:                 state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assign ev_clear = (state == ST_IDLE);
  assign ev_load  = (state == ST_IDLE) && !go;
  assign ev_shift = (state == ST_COUNT);
  assign fin      = (state == ST_DONE);

  a_r5_zero_exits: assert property (@(posedge clk) disable iff (rst)
    (ev_shift && opnd_zero) |=> fin);

  a_r6_hold_done: assert property (@(posedge clk) disable iff (rst)
    (fin && go) |=> fin);

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (fin && !go) |=> ev_clear);

  a_r2_idle_until_go: assert property (@(posedge clk) disable iff (rst)
    (ev_clear && !go) |=> ev_clear);

endmodule

// File: rtl/ones_dpath.sv
module ones_dpath
  import ones_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CW = tally_width(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              ev_load,
  input  logic              ev_clear,
  input  logic              ev_shift,
  output logic              opnd_zero,
  output logic [CW-1:0]     tally
);

  logic [DATA_W-1:0] opnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd  <= '0;
      tally <= '0;
    end else begin
      if (ev_load)       opnd <= din;
      else if (ev_shift) opnd <= opnd >> 1;
      if (ev_clear)      tally <= '0;
      else if (ev_shift) tally <= tally + CW'(opnd[0]);
    end
  end

  assign opnd_zero = (opnd == '0);

  a_r2_cleared: assert property (@(posedge clk) disable iff (rst)
    ev_clear |=> (tally == '0));

  a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
    tally <= CW'(DATA_W));

  a_r8_no_reload: assert property (@(posedge clk) disable iff (rst)
    (ev_shift && !opnd_zero) |=> (opnd == ($past(opnd) >> 1)));

endmodule

// File: rtl/ones_counter.sv
module ones_counter
  import ones_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = tally_width(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  output logic [CW-1:0]     ones,
  output logic              busy_done
);

  logic go, opnd_zero, ev_load, ev_clear, ev_shift;

  ones_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(start), .q_sync(go)
  );

  ones_ctrl u_ctrl (
    .clk(clk), .rst(rst), .go(go), .opnd_zero(opnd_zero),
    .ev_load(ev_load), .ev_clear(ev_clear), .ev_shift(ev_shift),
    .fin(busy_done)
  );

  ones_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .din(din),
    .ev_load(ev_load), .ev_clear(ev_clear), .ev_shift(ev_shift),
    .opnd_zero(opnd_zero), .tally(ones)
  );

  a_r6_stable_result: assert property (@(posedge clk) disable iff (rst)
    (busy_done && $past(busy_done)) |-> $stable(ones));

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!busy_done && ones == '0));

endmodule

// File: tb/tb_ones_counter.sv
module tb_ones_counter;

  localparam int DW = 8;
  localparam int SS = 2;
  localparam int CW = $clog2(DW + 1);

  logic          clk = 0;
  logic          rst = 1;
  logic          start = 0;
  logic [DW-1:0] din = '0;
  logic [CW-1:0] ones;
  logic          busy_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ones_counter #(.DATA_W(DW), .SYNC_STAGES(SS)) dut (
    .clk(clk), .rst(rst), .start(start), .din(din),
    .ones(ones), .busy_done(busy_done)
  );

  function automatic int bits_set(input logic [DW-1:0] w);
    int c = 0;
    for (int i = 0; i < DW; i++) if (w[i]) c++;
    return c;
  endfunction

  function automatic int span(input logic [DW-1:0] w);
    int s = 0;
    for (int i = 0; i < DW; i++) if (w[i]) s = i + 1;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // One full handshake on word w; optionally scramble din during counting.
  task automatic run_word(input logic [DW-1:0] w, input bit scramble);
    int edges = 0;
    int exp_lat = SS + 2 + span(w);
    logic [CW-1:0] held;
    @(negedge clk); din = w;
    @(negedge clk); start = 1;
    while (!busy_done && edges < 40) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (scramble && edges == SS + 2) din = ~w; // R8: after capture
    end
    check("R4 latency", edges, exp_lat);
    check(scramble ? "R8 result" : "R3 result", int'(ones), bits_set(w));
    if (w == '0) check("R5 zero word", int'(ones), 0);
    held = ones;
    for (int k = 0; k < 3; k++) begin
      din = DW'($urandom);
      @(negedge clk);
      check("R6 done held", int'(busy_done), 1);
      check("R6 result stable", int'(ones), int'(held));
    end
    start = 0;
    edges = 0;
    while (busy_done && edges < 40) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    check("R7 release latency", edges, SS + 1);
    @(negedge clk);
    check("R7 cleared in idle", int'(ones), 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(busy_done), 0);
    check("R1 reset ones", int'(ones), 0);
    rst = 0;
    // R2: idle tracking; count reads 0 for a while with start low.
    for (int k = 0; k < 4; k++) begin
      din = DW'($urandom);
      @(negedge clk);
      check("R2 idle ones", int'(ones), 0);
      check("R2 idle done", int'(busy_done), 0);
    end
    run_word('0, 0);
    run_word(8'h01, 0);
    run_word(8'h80, 0);
    run_word(8'hFF, 0);
    run_word(8'h55, 0);
    run_word(8'hAA, 1);
    run_word(8'h80, 1);
    for (int t = 0; t < 300; t++) begin
      logic [DW-1:0] w = DW'($urandom);
      run_word(w, t[0]);
      check("R9 bound", int'(ones <= CW'(DW)), 1);
    end
    finish_run();
  end

endmodule